// File: doc/BRIEF.md
# Two-Word-per-Cycle Dictionary Line Compressor

This block compresses a 64-byte cache line, taken as sixteen 32-bit words, into variable-length code words. Each cycle it accepts a pair of words. Both words are tested in parallel against two fixed patterns: an all-zero word, and a small integer whose upper three bytes are zero. Both are also tested against a 16-entry dictionary of 32-bit words. The dictionary starts empty for every line and fills as the line streams in. Each word that is not a fixed pattern is written to the next free slot.

The second word of a pair has to see the dictionary as it would stand after the first word was encoded. When the first word is inserted, the second word's view of the dictionary has the slot that the first word takes overwritten by the first word. That slot carries its own index. The code stream is therefore bit-identical to encoding the words one at a time. One cycle after each pair, the block presents both code words joined into one right-aligned field, with its length in bits. With the eighth pair it also raises a line-complete pulse and the line's total compressed size.

Top module: `pair_word_compressor`

## Requirements
- R1: A word equal to zero yields the 2-bit code `00` with no payload and is not inserted into the dictionary.
- R2: A nonzero word whose bits 31..8 are zero yields the 12-bit code `1101` followed by bits 7..0, and is not inserted.
- R3: A word equal to a valid dictionary entry yields the 6-bit code `10` followed by the 4-bit entry index.
- R4: A word whose bits 31..8 match an entry, but which is not a full match, yields the 16-bit code `1110`, then bits 7..0, then the 4-bit index.
- R5: A word whose bits 31..16 match an entry, with no better match, yields the 24-bit code `1100`, then bits 15..0, then the 4-bit index.
- R6: A word with no pattern and no match yields the 34-bit code `01` followed by the full 32-bit word.
- R7: The order of preference is zero, small integer, full match, three-byte match, two-byte match, literal. Among entries with the same kind of match, the lowest index is chosen.
- R8: Words that are not fixed patterns are inserted in stream order into indices 0, 1, 2 and so on, with the first word of a pair placed before the second.
- R9: The code for the second word of a pair equals the code it would get under serial encoding. This covers the case where its match is the first word of the same pair.
- R10: One cycle after a valid pair, `out_valid_o` is high. `pair_code_o` then holds code0 followed by code1, right-aligned, with code0 in the upper bits. `pair_len_o` holds the sum of the two lengths. A cycle without `valid_i` produces no output.
- R11: Every eighth valid pair closes a line. `line_done_o` rises with that pair's output, and `line_bits_o` carries the sum of all sixteen code lengths. The next pair starts with an empty dictionary.
- R12: After reset, `out_valid_o` and `line_done_o` are low, and the next pair is the first pair of a line with an empty dictionary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A word pair is presented |
| word0_i | input | 32 | Earlier word of the pair |
| word1_i | input | 32 | Later word of the pair |
| out_valid_o | output | 1 | Packed codes for a pair are valid |
| pair_code_o | output | 68 | Code0 then code1, right-aligned |
| pair_len_o | output | 7 | Bit length of pair_code_o |
| line_done_o | output | 1 | Pulse with the last pair of a line |
| line_bits_o | output | 10 | Compressed size of the finished line in bits |

## Verification
Suppose the dictionary holds a stale or misplaced entry, or its write pointer has drifted. The next word that refers back to an earlier word then shows the error at the ports one cycle later: the index in its code is wrong, or a full match comes out as a longer partial or literal code. A pair-hazard fault shows only on the second word of a pair whose first word was inserted, so stimulus repeats and perturbs words within a pair as well as across pairs. A miscounted line boundary shows at the latest on the next `line_done_o`, as a misplaced pulse or a wrong total, and on the first pair after it, as a dictionary that was not emptied.

// File: rtl/cpk_pkg.sv
package cpk_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = WORD_W + 2;  // literal is the longest code
  localparam int LEN_W  = $clog2(CODE_W + 1);

  typedef enum logic [2:0] {
    K_ZERO, K_SMALL, K_FULL, K_HI3, K_HI2, K_MISS
  } kind_e;
endpackage

// File: rtl/cpk_word_enc.sv
module cpk_word_enc
  import cpk_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [WORD_W-1:0]              word_i,
  input  logic [ENTRIES-1:0][WORD_W-1:0] dict_i,
  input  logic [ENTRIES-1:0]             valid_i,
  output logic [CODE_W-1:0]              code_o,
  output logic [LEN_W-1:0]               len_o,
  output logic                           insert_o
);
  logic             full_hit, hi3_hit, hi2_hit;
  logic [IDX_W-1:0] full_idx, hi3_idx, hi2_idx;
  kind_e            kind;

  // scan downwards so the lowest matching index is kept
  always_comb begin
    full_hit = 1'b0; hi3_hit = 1'b0; hi2_hit = 1'b0;
    full_idx = '0;   hi3_idx = '0;   hi2_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_i[i] && dict_i[i] == word_i) begin
        full_hit = 1'b1; full_idx = IDX_W'(i);
      end
      if (valid_i[i] && dict_i[i][WORD_W-1:8] == word_i[WORD_W-1:8]) begin
        hi3_hit = 1'b1; hi3_idx = IDX_W'(i);
      end
      if (valid_i[i] && dict_i[i][WORD_W-1:16] == word_i[WORD_W-1:16]) begin
        hi2_hit = 1'b1; hi2_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (word_i == '0)                     kind = K_ZERO;
    else if (word_i[WORD_W-1:8] == '0)    kind = K_SMALL;
    else if (full_hit)                    kind = K_FULL;
    else if (hi3_hit)                     kind = K_HI3;
    else if (hi2_hit)                     kind = K_HI2;
    else                                  kind = K_MISS;
  end

  always_comb begin
    unique case (kind)
      K_ZERO:  begin code_o = '0; len_o = LEN_W'(2); end
      K_SMALL: begin
        code_o = CODE_W'({4'b1101, word_i[7:0]});
        len_o  = LEN_W'(12);
      end
      K_FULL:  begin
        code_o = CODE_W'({2'b10, full_idx});
        len_o  = LEN_W'(2 + IDX_W);
      end
      K_HI3:   begin
        code_o = CODE_W'({4'b1110, word_i[7:0], hi3_idx});
        len_o  = LEN_W'(12 + IDX_W);
      end
      K_HI2:   begin
        code_o = CODE_W'({4'b1100, word_i[15:0], hi2_idx});
        len_o  = LEN_W'(20 + IDX_W);
      end
      default: begin
        code_o = CODE_W'({2'b01, word_i});
        len_o  = LEN_W'(CODE_W);
      end
    endcase
  end

  assign insert_o = (kind != K_ZERO) && (kind != K_SMALL);
endmodule

// File: rtl/cpk_dict.sv
module cpk_dict
  import cpk_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           en_i,
  input  logic                           clr_i,
  input  logic                           ins0_i,
  input  logic                           ins1_i,
  input  logic [WORD_W-1:0]              word0_i,
  input  logic [WORD_W-1:0]              word1_i,
  output logic [ENTRIES-1:0][WORD_W-1:0] dict_o,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [IDX_W-1:0]               wptr_o
);
  logic [ENTRIES-1:0][WORD_W-1:0] entry_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [IDX_W-1:0]               wptr_q, wptr1;

  assign wptr1 = wptr_q + IDX_W'(ins0_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wptr_q  <= '0;
    end else if (en_i) begin
      if (clr_i) begin
        valid_q <= '0;
        wptr_q  <= '0;
      end else begin
        if (ins0_i) valid_q[wptr_q] <= 1'b1;
        if (ins1_i) valid_q[wptr1]  <= 1'b1;
        wptr_q <= wptr1 + IDX_W'(ins1_i);
      end
    end
  end

  // data needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (en_i && !clr_i) begin
      if (ins0_i) entry_q[wptr_q] <= word0_i;
      if (ins1_i) entry_q[wptr1]  <= word1_i;
    end
  end

  assign dict_o  = entry_q;
  assign valid_o = valid_q;
  assign wptr_o  = wptr_q;

  // R11
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i |=> valid_q == '0 && wptr_q == '0);
  // R8
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q & (valid_q + 1'b1)) == '0);
endmodule

// File: rtl/pair_word_compressor.sv
module pair_word_compressor
  import cpk_pkg::*;
#(
  parameter int WORDS   = 16,
  parameter int ENTRIES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [31:0]             word0_i,
  input  logic [31:0]             word1_i,
  output logic                    out_valid_o,
  output logic [67:0]             pair_code_o,
  output logic [6:0]              pair_len_o,
  output logic                    line_done_o,
  output logic [9:0]              line_bits_o
);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int PAIRS   = WORDS / 2;
  localparam int PCNT_W  = $clog2(PAIRS);
  localparam int PAIR_W  = 2 * CODE_W;
  localparam int PLEN_W  = LEN_W + 1;
  localparam int BITS_W  = $clog2(WORDS * CODE_W + 1);

  logic [ENTRIES-1:0][WORD_W-1:0] dict0, dict1;
  logic [ENTRIES-1:0]             valid0, valid1;
  logic [IDX_W-1:0]               wptr;
  logic [CODE_W-1:0]              code0, code1;
  logic [LEN_W-1:0]               len0, len1;
  logic                           ins0, ins1, last;
  logic [PCNT_W-1:0]              pcnt_q;
  logic [BITS_W-1:0]              acc_q, acc_nxt;

  cpk_dict #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_dict (
    .clk_i, .rst_ni, .en_i(valid_i), .clr_i(last),
    .ins0_i(ins0), .ins1_i(ins1), .word0_i, .word1_i,
    .dict_o(dict0), .valid_o(valid0), .wptr_o(wptr)
  );

  // second word sees the dictionary after the first word's insertion
  for (genvar g = 0; g < ENTRIES; g++) begin : g_view
    logic hit;
    assign hit       = ins0 && (wptr == IDX_W'(g));
    assign dict1[g]  = hit ? word0_i : dict0[g];
    assign valid1[g] = valid0[g] | hit;
  end

  cpk_word_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_enc0 (
    .word_i(word0_i), .dict_i(dict0), .valid_i(valid0),
    .code_o(code0), .len_o(len0), .insert_o(ins0)
  );
  cpk_word_enc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_enc1 (
    .word_i(word1_i), .dict_i(dict1), .valid_i(valid1),
    .code_o(code1), .len_o(len1), .insert_o(ins1)
  );

  assign last    = valid_i && (pcnt_q == PCNT_W'(PAIRS - 1));
  assign acc_nxt = acc_q + BITS_W'(len0) + BITS_W'(len1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      pair_code_o <= '0;
      pair_len_o  <= '0;
      line_done_o <= 1'b0;
      line_bits_o <= '0;
      pcnt_q      <= '0;
      acc_q       <= '0;
    end else begin
      out_valid_o <= valid_i;
      line_done_o <= last;
      if (valid_i) begin
        pair_code_o <= (PAIR_W'(code0) << len1) | PAIR_W'(code1);
        pair_len_o  <= PLEN_W'(len0) + PLEN_W'(len1);
        if (last) begin
          line_bits_o <= acc_nxt;
          acc_q       <= '0;
          pcnt_q      <= '0;
        end else begin
          acc_q  <= acc_nxt;
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  // R1
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && word0_i == '0 |-> len0 == LEN_W'(2) && !ins0);
  // R9
  hazard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ins0 && word1_i == word0_i |-> len1 == LEN_W'(2 + IDX_W));
  // R10
  len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> pair_len_o >= PLEN_W'(4) && pair_len_o <= PLEN_W'(PAIR_W));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o && !line_done_o);
  // R11
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> out_valid_o && line_bits_o >= BITS_W'(2 * WORDS));
endmodule

// File: tb/test_pair_word_compressor.sv
`timescale 1ns/1ps
module test_pair_word_compressor;
  logic        clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [31:0] w0 = '0, w1 = '0;
  logic        out_valid, line_done;
  logic [67:0] pair_code;
  logic [6:0]  pair_len;
  logic [9:0]  line_bits;

  int checks = 0, errors = 0;
  logic [31:0] mdict[16];
  int mcnt = 0, mpairs = 0, mtotal = 0;
  logic [31:0] hist[16];
  int hn = 0;

  always #2 clk = ~clk;

  pair_word_compressor i_pair_word_compressor (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .word0_i(w0), .word1_i(w1),
    .out_valid_o(out_valid), .pair_code_o(pair_code), .pair_len_o(pair_len),
    .line_done_o(line_done), .line_bits_o(line_bits)
  );

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // serial reference encoder
  task automatic menc(input logic [31:0] w, output logic [33:0] c, output int l,
                      output string t);
    int f, h3, h2;
    f = -1; h3 = -1; h2 = -1;
    for (int i = mcnt - 1; i >= 0; i--) begin
      if (mdict[i] == w) f = i;
      if (mdict[i][31:8] == w[31:8]) h3 = i;
      if (mdict[i][31:16] == w[31:16]) h2 = i;
    end
    if (w == 0) begin c = '0; l = 2; t = "R1"; end
    else if (w[31:8] == 0) begin c = {22'b0, 4'b1101, w[7:0]}; l = 12; t = "R2"; end
    else begin
      if (f >= 0)       begin c = {28'b0, 2'b10, f[3:0]}; l = 6; t = "R3/R7"; end
      else if (h3 >= 0) begin c = {18'b0, 4'b1110, w[7:0], h3[3:0]}; l = 16; t = "R4/R7"; end
      else if (h2 >= 0) begin c = {10'b0, 4'b1100, w[15:0], h2[3:0]}; l = 24; t = "R5/R7"; end
      else              begin c = {2'b01, w}; l = 34; t = "R6"; end
      mdict[mcnt] = w; // R8 FIFO slot order
      mcnt++;
    end
  endtask

  task automatic send_pair(input logic [31:0] a, input logic [31:0] b);
    logic [33:0] c0, c1;
    int l0, l1;
    string t0, t1, tag;
    logic [67:0] e;
    menc(a, c0, l0, t0);
    menc(b, c1, l1, t1);
    tag = {t0, "+", t1, (t0.len() > 2 || t0 == "R3" || t0 == "R6") ? "/R9" : ""};
    e = ({34'b0, c0} << l1) | {34'b0, c1};
    mtotal += l0 + l1;
    mpairs++;
    @(negedge clk); valid = 1'b1; w0 = a; w1 = b;
    @(posedge clk); #1;
    valid = 1'b0;
    chk({"R10 valid ", tag}, {67'b0, out_valid}, 68'd1);
    chk({"R10 code ", tag}, pair_code, e);
    chk({"R10 len ", tag}, {61'b0, pair_len}, 68'(l0 + l1));
    if (mpairs == 8) begin
      chk("R11 done", {67'b0, line_done}, 68'd1);
      chk("R11 bits", {58'b0, line_bits}, 68'(mtotal));
      mpairs = 0; mtotal = 0; mcnt = 0;
    end else chk("R11 no done", {67'b0, line_done}, 68'd0);
  endtask

  task automatic stall();
    @(negedge clk); valid = 1'b0;
    @(posedge clk); #1;
    chk("R10 idle", {66'b0, out_valid, line_done}, 68'd0);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] h;
    int k;
    k = $urandom % 7;
    if (hn == 0 && k >= 2 && k <= 4) k = 5;
    if (hn > 0) h = hist[$urandom % hn];
    else h = '0;
    case (k)
      0: return '0;
      1: return {24'b0, 8'($urandom % 255 + 1)};
      2: return h;
      3: return h ^ {24'b0, 8'($urandom % 255 + 1)};
      4: return h ^ {16'b0, 8'($urandom % 255 + 1), 8'($urandom)};
      default: return {8'($urandom % 255 + 1), 24'($urandom)};
    endcase
  endfunction

  task automatic send_line(input logic [31:0] ws[16], input bit stalls);
    for (int p = 0; p < 8; p++) begin
      if (stalls && ($urandom % 4 == 0)) stall();
      send_pair(ws[2*p], ws[2*p+1]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ws[16];
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 reset", {66'b0, out_valid, line_done}, 68'd0);
    @(negedge clk); rst_n = 1'b1;
    stall();

    // R1 all zero line: 32 bits
    for (int i = 0; i < 16; i++) ws[i] = '0;
    send_line(ws, 1'b0);
    // R2 small integers
    for (int i = 0; i < 16; i++) ws[i] = 32'(i + 1);
    send_line(ws, 1'b0);
    // R6 all literal, R8 fills slots 0..15
    for (int i = 0; i < 16; i++) ws[i] = {8'(8'hA0 + i), 24'h135799};
    send_line(ws, 1'b0);
    // R3 R8: repeats of the previous distinct words must reach back into fresh (cleared) dict -> literal again, then hits
    for (int i = 0; i < 8; i++) ws[i] = {8'(8'hA0 + i), 24'h135799};
    for (int i = 8; i < 16; i++) ws[i] = {8'(8'hA0 + 15 - i), 24'h135799};
    send_line(ws, 1'b1);
    // R7 priority and lowest index; R9 pair hazards
    ws[0]  = 32'h11223344; ws[1]  = 32'h11223355; // hi3 on word0 of same pair
    ws[2]  = 32'h11223355; ws[3]  = 32'h11229999; // full idx1 beats hi3 idx0; hi2 idx0
    ws[4]  = 32'h5566_7788; ws[5]  = 32'h5566_7788; // R9 full match on word0 slot
    ws[6]  = 32'h0;        ws[7]  = 32'h5566_7788; // fixed word0: unchanged dict
    ws[8]  = 32'h7000_0001; ws[9] = 32'h7000_0102; // R9 hi2 against word0
    ws[10] = 32'h11223344; ws[11] = 32'h0000_00FF;
    ws[12] = 32'h9999_0000; ws[13] = 32'h9999_00AB;
    ws[14] = 32'h5566_7788; ws[15] = 32'h1122_3355;
    send_line(ws, 1'b0);

    // constrained random lines
    for (int n = 0; n < 80; n++) begin
      hn = 0;
      for (int i = 0; i < 16; i++) begin
        ws[i] = pick();
        hist[hn] = ws[i]; hn++;
      end
      send_line(ws, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule